// File: doc/BRIEF.md
# Two-Party Bus Arbiter with Grant Parking

This block decides who owns a shared external bus: a local controller inside the chip or one external master. The external master asks for the bus on a request input. The arbiter answers on a grant output and pulls a shared busy line while the local side is using the bus. When the local side has nothing to do, the grant stays with the external master, which is then parked on the bus. A parked master may begin further transfers by raising the busy line alone, without asking again. The external master must treat the grant as valid only while the busy line is low.

The local controller raises a request and waits for its granted output. It holds the bus until it pulses a done input. Before granting the local side, the arbiter requires the busy line to have been seen low on a configurable number of consecutive clock edges; the default is two. A mode input selects single-master operation. In that mode the arbiter drives nothing onto the shared lines, ignores them, and serves the local side directly.

All outputs are registered. Reset is synchronous and active high.

Top module: `bus_park_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, `bg_out`, `bb_drive` and `loc_gnt` are 0 after that edge.
- R2: With `multi_en` = 0, `bg_out` and `bb_drive` stay 0 whatever `br_in` and `bb_in` do. `loc_gnt` rises at the edge that samples `loc_req` high and falls at the edge that samples `loc_done` high.
- R3: With `multi_en` = 1 and `bg_out` = 0, `loc_gnt` rises only at an edge that samples `loc_req` high and follows IDLE_CYCLES consecutive edges on which the busy line (`bb_in` or the arbiter's own drive) was low, with the arbiter not granting the local side.
- R4: `bb_drive` rises one edge after `loc_gnt` rises, provided `loc_done` is low. It stays high until the edge that samples `loc_done` high. At that edge `bb_drive` and `loc_gnt` both fall.
- R5: With `multi_en` = 1 and no grant held, an edge that samples `br_in` high, and either `loc_req` low or the idle condition of R3 unmet, sets `bg_out`.
- R6: When the idle condition of R3 holds and both `loc_req` and `br_in` are high, the local side wins: `loc_gnt` rises and `bg_out` stays 0.
- R7: Once `bg_out` is high, it stays high while `loc_req` is low and `multi_en` is 1, even after `br_in` falls (parking). The external master may toggle `bb_in` during this time.
- R8: While `bg_out` is high, an edge that samples `br_in` low and `loc_req` high clears `bg_out`.
- R9: If `br_in` is held high while the local side owns the bus, `bg_out` stays 0 until `loc_gnt` falls, and it rises on the next edge.
- R10: `bg_out` is never high in the same cycle as `loc_gnt` or `bb_drive`.
- R11: An edge that samples `multi_en` low while `bg_out` is high clears `bg_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| multi_en | input | 1 | 1 = shared bus with an external master, 0 = single-master |
| br_in | input | 1 | Bus request from the external master |
| bb_in | input | 1 | Sampled level of the shared busy line, 1 = busy |
| bg_out | output | 1 | Bus grant to the external master |
| bb_drive | output | 1 | 1 = arbiter pulls the busy line active |
| loc_req | input | 1 | Local controller requests the bus |
| loc_done | input | 1 | Local controller finished its transfer |
| loc_gnt | output | 1 | Local controller owns the bus |

## Verification
The bench builds the block with IDLE_CYCLES = 2, the default. With this value the cycle counts can be traced by hand: a local grant comes on the third edge after the busy line falls. At this depth the difference between an idle count that is just short and one that is just met also shows up on specific cycles. A behavioural model of the busy line, in which the line is high when either the external master or the arbiter pulls it, lets the bench check the clearing of the idle count on every clock through directed hand-overs and a long pseudo-random stretch.

// File: rtl/bpa_pkg.sv
package bpa_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_EXT  = 2'd1,
        ARB_LOC  = 2'd2
    } arb_state_e;

    typedef struct packed {
        arb_state_e state;
        logic       bb_drv;
    } fsm_regs_t;

endpackage

// File: rtl/bpa_idle_tracker.sv
module bpa_idle_tracker #(
    parameter int IDLE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic line_busy,
    output logic idle_ok
);
    localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_CYCLES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    // Count consecutive low samples of the busy line, saturating at LIMIT.
    always_comb begin
        cnt_d = cnt_q;
        if (!enable || line_busy) begin
            cnt_d = '0;
        end else if (cnt_q != LIMIT) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign idle_ok = (cnt_q == LIMIT);

endmodule

// File: rtl/bpa_grant_fsm.sv
module bpa_grant_fsm
    import bpa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic multi_en,
    input  logic br_in,
    input  logic loc_req,
    input  logic loc_done,
    input  logic idle_ok,
    output logic bg_out,
    output logic loc_gnt,
    output logic bb_drive
);
    fsm_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.state)
            ARB_IDLE: begin
                if (!multi_en) begin
                    if (loc_req) regs_d.state = ARB_LOC;
                end else if (loc_req && idle_ok) begin
                    regs_d.state = ARB_LOC;
                end else if (br_in) begin
                    regs_d.state = ARB_EXT;
                end
            end
            ARB_EXT: begin
                // Grant stays parked unless the mode drops or a local
                // request is waiting once the external request is gone.
                if (!multi_en || (!br_in && loc_req)) regs_d.state = ARB_IDLE;
            end
            ARB_LOC: begin
                if (loc_done) regs_d.state = ARB_IDLE;
            end
            default: regs_d.state = ARB_IDLE;
        endcase
        // Busy drive starts one cycle after the local grant.
        regs_d.bb_drv = (regs_q.state == ARB_LOC) && !loc_done && multi_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '{state: ARB_IDLE, bb_drv: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bg_out   = (regs_q.state == ARB_EXT);
    assign loc_gnt  = (regs_q.state == ARB_LOC);
    assign bb_drive = regs_q.bb_drv;

endmodule

// File: rtl/bus_park_arbiter.sv
module bus_park_arbiter #(
    parameter int IDLE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic multi_en,
    input  logic br_in,
    input  logic bb_in,
    output logic bg_out,
    output logic bb_drive,
    input  logic loc_req,
    input  logic loc_done,
    output logic loc_gnt
);
    logic idle_ok;
    logic line_busy;

    // The line counts as busy while the local side holds the bus,
    // so a hand-over always restarts the idle window.
    assign line_busy = bb_in | bb_drive | loc_gnt;

    bpa_idle_tracker #(
        .IDLE_CYCLES(IDLE_CYCLES)
    ) u_idle (
        .clk      (clk),
        .rst      (rst),
        .enable   (multi_en),
        .line_busy(line_busy),
        .idle_ok  (idle_ok)
    );

    bpa_grant_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .multi_en(multi_en),
        .br_in   (br_in),
        .loc_req (loc_req),
        .loc_done(loc_done),
        .idle_ok (idle_ok),
        .bg_out  (bg_out),
        .loc_gnt (loc_gnt),
        .bb_drive(bb_drive)
    );

endmodule

// File: rtl/bus_park_arbiter_chk.sv
module bus_park_arbiter_chk #(
    parameter int IDLE_CYCLES = 2
) (
    input logic clk,
    input logic rst,
    input logic multi_en,
    input logic br_in,
    input logic bb_in,
    input logic bg_out,
    input logic bb_drive,
    input logic loc_req,
    input logic loc_done,
    input logic loc_gnt
);
    localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_CYCLES);

    // Independent run length of low busy samples (no ownership clearing).
    logic [CNT_W-1:0] low_run_q;
    always_ff @(posedge clk) begin
        if (rst || bb_in || bb_drive) begin
            low_run_q <= '0;
        end else if (low_run_q != LIMIT) begin
            low_run_q <= low_run_q + 1'b1;
        end
    end

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!bg_out && !bb_drive && !loc_gnt));

    p_single_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !multi_en |=> (!bg_out && !bb_drive));

    p_idle_qual_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(loc_gnt) && $past(multi_en)) |-> ($past(low_run_q) == LIMIT));

    p_drive_after_gnt_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(bb_drive) |-> (loc_gnt && $past(loc_gnt)));

    p_drive_release_r4: assert property (@(posedge clk) disable iff (rst)
        (loc_gnt && loc_done) |=> (!bb_drive && !loc_gnt));

    p_park_r7: assert property (@(posedge clk) disable iff (rst)
        (bg_out && !loc_req && multi_en) |=> bg_out);

    p_bg_drop_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(bg_out) |-> ($past(!br_in && loc_req) || $past(!multi_en)));

    p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        !(bg_out && (loc_gnt || bb_drive)));

endmodule

bind bus_park_arbiter bus_park_arbiter_chk #(
    .IDLE_CYCLES(IDLE_CYCLES)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .multi_en(multi_en),
    .br_in   (br_in),
    .bb_in   (bb_in),
    .bg_out  (bg_out),
    .bb_drive(bb_drive),
    .loc_req (loc_req),
    .loc_done(loc_done),
    .loc_gnt (loc_gnt)
);

// File: tb/bus_park_arbiter_test.sv
module bus_park_arbiter_test;
    localparam int IDLE = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic multi_en = 1'b0;
    logic br_in = 1'b0;
    logic ext_bb = 1'b0;
    logic loc_req = 1'b0;
    logic loc_done = 1'b0;
    logic bb_in;
    logic bg_out, bb_drive, loc_gnt;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // Reference model: 0 = nobody, 1 = external, 2 = local.
    int m_owner = 0;
    int m_low = 0;
    bit m_drv = 0;

    always #10 clk = ~clk;

    assign bb_in = ext_bb | bb_drive;

    bus_park_arbiter #(.IDLE_CYCLES(IDLE)) uut (
        .clk(clk), .rst(rst), .multi_en(multi_en), .br_in(br_in),
        .bb_in(bb_in), .bg_out(bg_out), .bb_drive(bb_drive),
        .loc_req(loc_req), .loc_done(loc_done), .loc_gnt(loc_gnt)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        int n_owner;
        bit line;
        line = ext_bb | m_drv;
        if (rst) begin
            m_owner = 0; m_low = 0; m_drv = 0;
            return;
        end
        n_owner = m_owner;
        if (m_owner == 0) begin
            if (!multi_en) begin
                if (loc_req) n_owner = 2;
            end else if (loc_req && m_low >= IDLE) n_owner = 2;
            else if (br_in) n_owner = 1;
        end else if (m_owner == 1) begin
            if (!multi_en || (!br_in && loc_req)) n_owner = 0;
        end else begin
            if (loc_done) n_owner = 0;
        end
        if (!multi_en || line || m_owner == 2) m_low = 0;
        else if (m_low < IDLE) m_low = m_low + 1;
        m_drv = (m_owner == 2) && !loc_done && multi_en;
        m_owner = n_owner;
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            check(cur_req, "bg_out", int'(bg_out), int'(m_owner == 1));
            check(cur_req, "loc_gnt", int'(loc_gnt), int'(m_owner == 2));
            check(cur_req, "bb_drive", int'(bb_drive), int'(m_drv));
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        step(3);
        check("R1", "bg_out in reset", int'(bg_out), 0);
        check("R1", "loc_gnt in reset", int'(loc_gnt), 0);
        check("R1", "bb_drive in reset", int'(bb_drive), 0);
        rst = 1'b0;

        // R2: single-master mode ignores shared lines
        cur_req = "R2";
        br_in = 1'b1; ext_bb = 1'b1;
        step(3);
        check("R2", "bg_out single mode", int'(bg_out), 0);
        loc_req = 1'b1;
        step(1);
        check("R2", "loc_gnt single mode", int'(loc_gnt), 1);
        step(2);
        check("R2", "bb_drive single mode", int'(bb_drive), 0);
        loc_req = 1'b0; loc_done = 1'b1;
        step(1);
        loc_done = 1'b0;
        check("R2", "loc_gnt release", int'(loc_gnt), 0);
        br_in = 1'b0; ext_bb = 1'b0;

        // R3: local grant waits for two low samples
        cur_req = "R3";
        multi_en = 1'b1; ext_bb = 1'b1; loc_req = 1'b1;
        step(3);
        check("R3", "loc_gnt while busy", int'(loc_gnt), 0);
        ext_bb = 1'b0;
        step(2);
        check("R3", "loc_gnt one short", int'(loc_gnt), 0);
        step(1);
        check("R3", "loc_gnt qualified", int'(loc_gnt), 1);

        // R4: busy drive follows the grant by one cycle
        cur_req = "R4";
        check("R4", "bb_drive same cycle", int'(bb_drive), 0);
        step(1);
        check("R4", "bb_drive next cycle", int'(bb_drive), 1);
        step(3);
        check("R4", "bb_drive held", int'(bb_drive), 1);
        loc_done = 1'b1; loc_req = 1'b0;
        step(1);
        loc_done = 1'b0;
        check("R4", "bb_drive released", int'(bb_drive), 0);
        check("R4", "loc_gnt released", int'(loc_gnt), 0);

        // R5: external request granted
        cur_req = "R5";
        br_in = 1'b1;
        step(1);
        check("R5", "bg_out on request", int'(bg_out), 1);

        // R7: parking after request drops
        cur_req = "R7";
        br_in = 1'b0;
        step(3);
        check("R7", "bg_out parked", int'(bg_out), 1);
        ext_bb = 1'b1;
        step(2);
        ext_bb = 1'b0;
        step(2);
        check("R7", "bg_out parked after reuse", int'(bg_out), 1);

        // R8: local request takes grant back
        cur_req = "R8";
        loc_req = 1'b1; ext_bb = 1'b1;
        step(1);
        check("R8", "bg_out dropped", int'(bg_out), 0);
        step(2);
        check("R8", "loc_gnt waits for busy", int'(loc_gnt), 0);
        ext_bb = 1'b0;
        step(3);
        check("R8", "loc_gnt after idle", int'(loc_gnt), 1);

        // R9: external request during local ownership
        cur_req = "R9";
        br_in = 1'b1;
        step(3);
        check("R9", "bg_out held off", int'(bg_out), 0);
        loc_done = 1'b1; loc_req = 1'b0;
        step(1);
        loc_done = 1'b0;
        check("R9", "bg_out at release", int'(bg_out), 0);
        step(1);
        check("R9", "bg_out after release", int'(bg_out), 1);

        // R11: mode drop clears the grant
        cur_req = "R11";
        multi_en = 1'b0;
        step(1);
        check("R11", "bg_out after mode drop", int'(bg_out), 0);

        // R6: local wins a tie when idle is qualified
        cur_req = "R6";
        multi_en = 1'b1; br_in = 1'b0;
        step(3);
        br_in = 1'b1; loc_req = 1'b1;
        step(1);
        check("R6", "loc_gnt on tie", int'(loc_gnt), 1);
        check("R6", "bg_out on tie", int'(bg_out), 0);
        loc_done = 1'b1; loc_req = 1'b0; br_in = 1'b0;
        step(1);
        loc_done = 1'b0;

        // R10: pseudo-random traffic against the model
        cur_req = "R10";
        for (int i = 0; i < 600; i++) begin
            multi_en = ($urandom % 16) != 0;
            br_in    = ($urandom % 3) == 0;
            ext_bb   = ($urandom % 4) == 0;
            loc_req  = ($urandom % 2) == 0;
            loc_done = ($urandom % 5) == 0;
            step(1);
            check("R10", "exclusive grant", int'(bg_out && (loc_gnt || bb_drive)), 0);
        end

        finished = 1;
        summary();
        $finish;
    end

endmodule